// File: doc/BRIEF.md
# General-Purpose I/O Port with Output-Disable Override

This block is one parallel I/O port of `WIDTH` pins (16 by default). Software writes and reads a data register over a simple strobe-based register bus. Two per-bit configuration vectors come from elsewhere in the chip. The first is a direction vector, where 1 means output. The second is a function-mode vector, where 1 means the pin is in general I/O use and 0 means another function owns it. For each pin the block drives an output value and an output enable, and it samples the pin input through a two-stage synchronizer.

A read is built one bit at a time. An output bit returns the stored register value. An input bit returns the synchronized pin level. A write always lands in the register. The value reaches a pad only when that bit is a general output and the active-low output-disable input is high. Pulling output-disable low releases every general output at once. The stored data is left intact, so driving resumes with the same values when the input returns high.

The register is cleared by the power-on reset and by either standby request. No other reset source clears it, so its contents survive every other low-power state.

Top module: `gpio_odport`

## Requirements
- R1: After `rst_n` is released, the stored register is all zeros: `pin_out` is 0, and a read with every direction bit at 1 returns 0.
- R2: A cycle with `wr_en` high loads `wr_data` into every bit of the stored register on that clock edge, whatever `dir` and `gpio_mode` hold. The new value appears on `pin_out` after the edge.
- R3: For a bit with `dir` = 0, a read returns the pin level from two rising edges earlier. A change on `pin_in` is first visible on `rd_data` after the second rising edge that follows it.
- R4: For a bit with `dir` = 1, a read returns the stored register bit, whatever level is on `pin_in`.
- R5: `pin_oe[n]` is 1 exactly when `dir[n]` = 1, `gpio_mode[n]` = 1 and `out_dis_n` = 1. Writes to any other bit reach no pad.
- R6: While `out_dis_n` is 0, every `pin_oe` bit is 0. The stored register keeps its contents and still accepts writes.
- R7: A cycle with `hw_stby` or `sw_stby` high clears the stored register on that edge. The clear wins over a write in the same cycle.
- R8: `rd_data` is the combinational result of the current state while `rd_en` is high, and is all zeros while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_stby | input | 1 | Hardware standby request; clears the register |
| sw_stby | input | 1 | Software standby request; clears the register |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | WIDTH | Write value |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Read value, valid in the strobe cycle |
| dir | input | WIDTH | Per-bit direction, 1 = output |
| gpio_mode | input | WIDTH | Per-bit function, 1 = general I/O |
| out_dis_n | input | 1 | Active-low global output disable |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad output enables |

## Verification
A register write and a standby clear can land on the same clock edge. The bench raises `wr_en` with a nonzero pattern and asserts `hw_stby` or `sw_stby` in that same cycle. After the edge it reads back with every direction bit at 1, and the expected result is all zeros on both the read and `pin_out`. A read issued in the cycle of a write must return the value from before the write. The bench checks this alongside the collision case.

// File: rtl/gpio_odport.sv
module gpio_odport #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] gpio_mode,
  input  logic             out_dis_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic             clear;

  assign clear = hw_stby | sw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (clear)  data_q <= '0;
    else if (wr_en)  data_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir & gpio_mode & {WIDTH{out_dis_n}};
  assign rd_data = rd_en ? ((dir & data_q) | (~dir & sync_q)) : '0;

endmodule

module gpio_odport_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] dir,
  input logic [WIDTH-1:0] gpio_mode,
  input logic             out_dis_n,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe
);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hw_stby && !sw_stby) |=> (pin_out == $past(wr_data)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !hw_stby && !sw_stby) |=> $stable(pin_out));

  assert_output_bits_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (((rd_data ^ pin_out) & dir) == '0));

  assert_oe_needs_general_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~(dir & gpio_mode)) == '0));

  assert_disable_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_dis_n |-> (pin_oe == '0));

  assert_standby_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stby || sw_stby) |=> (pin_out == '0));

  assert_idle_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

endmodule

bind gpio_odport gpio_odport_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/gpio_odport_test.sv
`timescale 1ns/1ps
module gpio_odport_test;
  localparam int W = 16;

  logic clk = 0, rst_n = 0, hw_stby = 0, sw_stby = 0, wr_en = 0, rd_en = 0, out_dis_n = 1;
  logic [W-1:0] wr_data = '0, dir = '0, gpio_mode = '0, pin_in = '0;
  logic [W-1:0] rd_data, pin_out, pin_oe;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  gpio_odport #(.WIDTH(W)) uut (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [W-1:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_read(output logic [W-1:0] v);
    rd_en = 1; #1 v = rd_data; rd_en = 0; #1;
  endtask

  function automatic logic [W-1:0] pat(input int i, input int s);
    return W'((i * 16'h9E37) ^ (i << 5) ^ s);
  endfunction

  initial begin
    #2000000;
    fails++; runs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    dir = '1;
    do_read(r); check("R1 read after reset", r, '0);
    check("R1 pin_out after reset", pin_out, '0);
    check("R8 idle read", rd_data, '0);

    for (int i = 1; i < 40; i++) begin
      logic [W-1:0] v, d, m, p;
      v = pat(i, 16'h1234); d = pat(i, 16'h0F0F); m = pat(i, 16'h3C5A); p = pat(i, 16'hA5C3);
      dir = d; gpio_mode = m; pin_in = p;
      do_write(v);
      check("R2 pin_out after write", pin_out, v);
      @(negedge clk); @(negedge clk);
      do_read(r); check("R3/R4 mixed read", r, (d & v) | (~d & p));
      dir = '1; pin_in = ~v; #1;
      do_read(r); check("R4 output read ignores pin", r, v);
      dir = d;
      out_dis_n = 1; #1; check("R5 oe", pin_oe, d & m);
      out_dis_n = 0; #1; check("R6 oe disabled", pin_oe, '0);
      out_dis_n = 1;
    end

    dir = '0; pin_in = 16'h00FF;
    @(negedge clk); @(negedge clk); @(negedge clk);
    pin_in = 16'hF0F0;
    @(negedge clk);
    do_read(r); check("R3 one edge still old", r, 16'h00FF);
    @(negedge clk);
    do_read(r); check("R3 two edges new", r, 16'hF0F0);

    out_dis_n = 0; dir = '1; gpio_mode = '1;
    do_write(16'hBEEF);
    do_read(r); check("R6 write stored while disabled", r, 16'hBEEF);
    check("R6 oe stays low", pin_oe, '0);
    out_dis_n = 1; #1;
    check("R6 resumes driving", pin_oe, '1);
    check("R6 value kept", pin_out, 16'hBEEF);

    @(negedge clk); wr_en = 1; wr_data = 16'h1357; rd_en = 1; #1;
    check("R8 read in write cycle is old", rd_data, 16'hBEEF);
    @(negedge clk); wr_en = 0; rd_en = 0;
    check("R2 write landed", pin_out, 16'h1357);

    @(negedge clk); hw_stby = 1;
    @(negedge clk); hw_stby = 0;
    do_read(r); check("R7 hw standby clears", r, '0);
    do_write(16'h5555);
    @(negedge clk); sw_stby = 1;
    @(negedge clk); sw_stby = 0;
    do_read(r); check("R7 sw standby clears", r, '0);
    do_write(16'hAAAA);
    @(negedge clk); wr_en = 1; wr_data = 16'h7777; hw_stby = 1;
    @(negedge clk); wr_en = 0; hw_stby = 0;
    do_read(r); check("R7 clear beats write", r, '0);
    check("R7 pin_out cleared", pin_out, '0);
    @(negedge clk); wr_en = 1; wr_data = 16'h7777; sw_stby = 1;
    @(negedge clk); wr_en = 0; sw_stby = 0;
    check("R7 sw clear beats write", pin_out, '0);

    do_write(16'hCAFE);
    rst_n = 0; #1;
    check("R1 async reset clears", pin_out, '0);
    @(negedge clk); rst_n = 1;
    check("R8 rd_en low", rd_data, '0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule